// File: doc/BRIEF.md
# Two-Class Priority Resolver

This block picks the winning interrupt source for each of two delivery classes: the normal class (IRQ) and the fast class (FIQ). It reads a rank table of 40 entries and three per-source vectors: pending, enabled and class steering. Each table entry carries a valid bit and a 6-bit source ID. The position of an entry in the table is its rank, and entry 0 outranks every other entry.

A source takes part in the search for a class when it is pending, enabled and steered to that class. The two classes are searched independently. Both winners are packed into one 32-bit status word, which the surrounding controller exposes as a read-only register. Storage of the table and access from the bus belong to that controller. The result is registered, so it appears one clock after its inputs.

Top module: `rank_resolver`

## Requirements
- R1: `hp_word` is registered. It shows the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low it holds 0x003F003F.
- R2: An entry whose `ent_vld` bit is 0 never contributes a winner.
- R3: An entry whose ID is 40 or greater (NSRC or greater) is skipped, even when it is valid.
- R4: Among the entries that qualify for a class, the one with the lowest table index supplies that class's winner.
- R5: A source qualifies for the FIQ class when its bits in `pend`, `en` and `fiq_sel` are all 1.
- R6: A source qualifies for the IRQ class when its bits in `pend` and `en` are 1 and its bit in `fiq_sel` is 0.
- R7: The word layout is as follows. Bit 31 is the IRQ-valid flag and bits 21:16 hold the IRQ winner ID. Bit 15 is the FIQ-valid flag and bits 5:0 hold the FIQ winner ID. Bits 30:22 and 14:6 are 0.
- R8: A class with no qualifying entry shows a valid flag of 0 and an ID field of 0x3F. With neither class qualifying, the word is 0x003F003F.
- R9: The IRQ and FIQ searches are independent, and both flags can be 1 in the same word.
- R10: The same ID may appear in several entries. The earliest valid entry that names it sets its rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_vld | input | NENT | Valid bit of each rank entry |
| ent_id | input | NENT x 6 | Source ID of each rank entry |
| pend | input | NSRC | Pending state per source |
| en | input | NSRC | Enable per source |
| fiq_sel | input | NSRC | 1 steers a source to FIQ, 0 to IRQ |
| hp_word | output | 32 | Registered winner status word |

## Verification
The IRQ search and the FIQ search can both produce a winner in the same cycle. The bench provokes this by steering one pending source to each class, and also through random tables in which many sources of both classes are pending at once. Each field is compared against an independent first-match scan from entry 0 upward. The bench checks that neither search masks the other and that the valid flags stay paired with their ID fields.

// File: rtl/rank_resolver.sv
module rank_resolver #(
  parameter int NENT = 40,
  parameter int NSRC = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NENT-1:0]      ent_vld,
  input  logic [NENT-1:0][5:0] ent_id,
  input  logic [NSRC-1:0]      pend,
  input  logic [NSRC-1:0]      en,
  input  logic [NSRC-1:0]      fiq_sel,
  output logic [31:0]          hp_word
);
  localparam int ID_W = 6;
  localparam int SPAN = 1 << ID_W;
  localparam logic [ID_W:0]   LIM  = ID_W'(NSRC) + 7'd0;
  localparam logic [ID_W-1:0] NONE = '1;

  logic [SPAN-1:0] live, to_fiq;
  assign live   = SPAN'(pend & en);
  assign to_fiq = SPAN'(fiq_sel);

  logic            f_hit, i_hit;
  logic [ID_W-1:0] f_id, i_id;

  always_comb begin
    f_hit = 1'b0;
    i_hit = 1'b0;
    f_id  = NONE;
    i_id  = NONE;
    for (int k = NENT - 1; k >= 0; k--) begin
      if (ent_vld[k] && ({1'b0, ent_id[k]} < LIM) && live[ent_id[k]]) begin
        if (to_fiq[ent_id[k]]) begin
          f_hit = 1'b1;
          f_id  = ent_id[k];
        end else begin
          i_hit = 1'b1;
          i_id  = ent_id[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hp_word <= 32'h003F_003F;
    else        hp_word <= {i_hit, 9'd0, i_id, f_hit, 9'd0, f_id};
  end
endmodule

// File: rtl/rank_resolver_chk.sv
module rank_resolver_chk #(
  parameter int NENT = 40,
  parameter int NSRC = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NENT-1:0]      ent_vld,
  input logic [NSRC-1:0]      pend,
  input logic [NSRC-1:0]      en,
  input logic [NSRC-1:0]      fiq_sel,
  input logic [31:0]          hp_word
);
  logic [63:0] q_live, q_fiq;
  logic        q_novld, seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_live  <= '0;
      q_fiq   <= '0;
      q_novld <= 1'b1;
      seen    <= 1'b0;
    end else begin
      q_live  <= 64'(pend & en);
      q_fiq   <= 64'(fiq_sel);
      q_novld <= (ent_vld == '0);
      seen    <= 1'b1;
    end
  end

  a_r8_irq_empty_id: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_word[31] |-> hp_word[21:16] == 6'h3F);
  a_r8_fiq_empty_id: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_word[15] |-> hp_word[5:0] == 6'h3F);
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[30:22] == 9'd0 && hp_word[14:6] == 9'd0);
  a_r6_irq_winner_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && hp_word[31]) |->
      (int'(hp_word[21:16]) < NSRC && q_live[hp_word[21:16]] && !q_fiq[hp_word[21:16]]));
  a_r5_fiq_winner_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && hp_word[15]) |->
      (int'(hp_word[5:0]) < NSRC && q_live[hp_word[5:0]] && q_fiq[hp_word[5:0]]));
  a_r2_no_valid_no_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && q_novld) |-> (!hp_word[31] && !hp_word[15]));
endmodule

bind rank_resolver rank_resolver_chk #(.NENT(NENT), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .pend(pend), .en(en),
  .fiq_sel(fiq_sel), .hp_word(hp_word)
);

// File: tb/rank_resolver_bench.sv
module rank_resolver_bench;
  localparam int NENT = 40;
  localparam int NSRC = 40;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NENT-1:0]      ent_vld = '0;
  logic [NENT-1:0][5:0] ent_id = '0;
  logic [NSRC-1:0]      pend = '0, en = '0, fiq_sel = '0;
  logic [31:0]          hp_word;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rank_resolver #(.NENT(NENT), .NSRC(NSRC)) u_rank_resolver (
    .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .ent_id(ent_id),
    .pend(pend), .en(en), .fiq_sel(fiq_sel), .hp_word(hp_word)
  );

  function automatic logic [31:0] model();
    logic [5:0] iid = 6'h3F, fid = 6'h3F;
    logic ih = 1'b0, fh = 1'b0;
    for (int k = 0; k < NENT; k++) begin
      int s = int'(ent_id[k]);
      if (ent_vld[k] && s < NSRC && pend[s] && en[s]) begin
        if (fiq_sel[s] && !fh) begin fh = 1'b1; fid = ent_id[k]; end
        if (!fiq_sel[s] && !ih) begin ih = 1'b1; iid = ent_id[k]; end
      end
    end
    return (32'(ih) << 31) | (32'(iid) << 16) | (32'(fh) << 15) | 32'(fid);
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    checks++;
    if (hp_word !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, hp_word, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [31:0] exp = model();
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic ident_table();
    ent_vld = '1;
    for (int k = 0; k < NENT; k++) ent_id[k] = 6'(k);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", 32'h003F_003F);
    rst_n = 1'b1;

    pend = '1; en = '1; ent_vld = '0;
    for (int k = 0; k < NENT; k++) ent_id[k] = 6'(k);
    step("R2 no valid entry");
    check("R8 empty word", 32'h003F_003F);

    ent_vld = '1;
    ent_id[0] = 6'd45; ent_id[1] = 6'd3; pend = '0; pend[3] = 1'b1;
    step("R3 out-of-range id skipped");
    check("R3 value", 32'h8003_003F);

    ident_table(); pend = '0; pend[7] = 1'b1; pend[20] = 1'b1; en = '1; fiq_sel = '0;
    #1 check("R1 latency holds old", 32'h8003_003F);
    step("R4 lowest index");
    check("R4 identity winner 7", 32'h8007_003F);
    for (int k = 0; k < NENT; k++) ent_id[k] = 6'(NENT - 1 - k);
    step("R4 reversed winner 20");
    check("R4 reversed value", 32'h8014_003F);

    ident_table(); pend = '0; pend[12] = 1'b1; fiq_sel = '0; fiq_sel[12] = 1'b1;
    step("R5 fiq winner");
    check("R5 value", 32'h003F_800C);
    en[12] = 1'b0;
    step("R6 disabled source");
    check("R8 disabled empty", 32'h003F_003F);

    en = '1; pend[30] = 1'b1;
    step("R9 both classes");
    check("R9 value", 32'h801E_800C);

    fiq_sel = '0; pend = '0; pend[9] = 1'b1; pend[4] = 1'b1;
    ent_id[0] = 6'd9; ent_id[1] = 6'd4; ent_id[3] = 6'd4; ent_id[5] = 6'd9;
    step("R10 duplicate ids");
    check("R10 value", 32'h8009_003F);

    ident_table();
    for (int s = 0; s < NSRC; s++) begin
      for (int m = 0; m < 3; m++) begin
        pend = '0; pend[s] = 1'b1; en = '0; en[s] = (m != 2); fiq_sel = '0; fiq_sel[s] = (m == 1);
        step("R7 single-source sweep");
      end
    end

    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < NENT; k++) begin
        ent_vld[k] = ($urandom_range(3) != 0);
        ent_id[k] = 6'($urandom_range(47));
      end
      pend = {$urandom, $urandom}; en = {$urandom, $urandom};
      fiq_sel = {$urandom, $urandom};
      if (n % 4 == 0) pend = pend & {$urandom, $urandom} & {$urandom, $urandom};
      step("R4 R9 random table");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule